// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates the interrupt requests of a small 8-bit processor core. It accepts eleven request flags. Each source has an enable bit and a priority bit, and a master enable gates all eleven at once. These settings sit in two writable control words. Request flags are captured on a machine-cycle strobe. The captured set is judged on the next strobe, so every decision rests on a sample exactly one machine cycle old. Nothing is remembered beyond that sample, so a flag that drops before it can be served is lost.

The winner is the lowest-numbered active source of the high level, or failing that of the low level. It is issued as a single-cycle call strobe with its source number and an entry address. The core confirms the call with an acknowledge, which marks that level as in service. A return strobe ends the most deeply nested service. A high-level call may interrupt a low-level service. Vectoring is withheld when the core reports that it is not in the final cycle of an instruction, that the instruction writes a control word, or that it is a return. The core itself saves the program counter and does no status save.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, no call is issued and no level is in service (`svc_lvl` = 2'b00), all per-source enables, priorities and the master enable are cleared, so a raised flag produces no call.
- R2: A source whose enable bit (bit i of the enable word, written with `cfg_sel`=0) is 0 is never called, whatever its flag.
- R3: With the master enable (bit 11 of the enable word) at 0, no source is called.
- R4: A flag present when `mc_tick` is high is captured at that edge, and the decision is taken at the next `mc_tick` edge. `call_o` is high in the cycle right after that decision edge.
- R5: High priority (bit i of the priority word, written with `cfg_sel`=1, set to 1) beats low. Within a level, the lowest source index wins.
- R6: A low-level request is not called while any level is in service. A high-level request is called while only low is in service (preemption) and is held off while high is in service.
- R7: No call is issued when, at the decision edge, `last_cyc` is 0, `reg_wr` is 1 or `reti_i` is 1.
- R8: A request blocked at one decision is not retained. If its captured flag is 0 at the next unblocked decision, it is not called.
- R9: `call_o` is a one-cycle strobe. `call_idx` gives the source index and `call_vec` gives 0x0003 + 8 × index.
- R10: `ack_i` after a call sets the called level's in-service bit (`svc_lvl[1]` for high, `svc_lvl[0]` for low). A strobe on `reti_i` clears the high bit if it is set, and otherwise clears the low bit. No new call is issued between a call and its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine-cycle start strobe |
| req_i | input | 11 | Interrupt request flags, one per source |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 1 | 0 selects enable word, 1 selects priority word |
| cfg_wdata | input | 12 | Write data; bit 11 is the master enable in the enable word |
| last_cyc | input | 1 | Core is in the final cycle of its instruction |
| reg_wr | input | 1 | Current instruction writes an enable or priority word |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_i | input | 1 | Core accepted the call |
| call_o | output | 1 | One-cycle call request |
| call_idx | output | 4 | Source index of the call |
| call_vec | output | 16 | Entry address of the call |
| svc_lvl | output | 2 | In-service bits: [1] high, [0] low |

## Verification
A call is due in the clock cycle after the second `mc_tick` edge that follows a flag change: one edge captures the flag and the next one decides. The in-service bits change one cycle after `ack_i` or `reti_i`. Every check samples on the falling edge that follows the edge where the result is registered. The expected call is queued before the deciding tick and taken from the queue in that same falling-edge slot. The bench then looks again one falling edge later to confirm that the strobe has dropped and that no other call appeared.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
   typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

   function automatic logic [15:0] entry_addr(input int unsigned base,
                                              input int unsigned stride,
                                              input int unsigned idx);
      return 16'(base + stride * idx);
   endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
   parameter int NSRC = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [NSRC-1:0] req_i,
   output logic [NSRC-1:0] samp_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    samp_o <= '0;
      else if (tick) samp_o <= req_i;
   end

   AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(samp_o)) else $error("sample moved off tick"); // R4
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NSRC  = 11,
   parameter int IDX_W = 4
) (
   input  logic [NSRC-1:0]  cand_i,
   output logic             vld_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [NSRC-1:0]  grant_o
);
   always_comb begin
      vld_o   = 1'b0;
      idx_o   = '0;
      grant_o = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (cand_i[i] && !vld_o) begin
            vld_o      = 1'b1;
            idx_o      = IDX_W'(i);
            grant_o[i] = 1'b1;
         end
      end
   end

   always_comb begin
      AST_GRANT_IN_CAND: assert ((grant_o & ~cand_i) == '0); // R5
   end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic set_hi_i,
   input  logic reti_i,
   output logic hi_o,
   output logic lo_o
);
   logic hi_n, lo_n;

   always_comb begin
      hi_n = hi_o;
      lo_n = lo_o;
      if (reti_i) begin
         if (hi_o) hi_n = 1'b0;
         else      lo_n = 1'b0;
      end
      if (set_i) begin
         if (set_hi_i) hi_n = 1'b1;
         else          lo_n = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_o <= 1'b0;
         lo_o <= 1'b0;
      end else begin
         hi_o <= hi_n;
         lo_o <= lo_n;
      end
   end

   AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (set_hi_i ? hi_o : lo_o) == 1'b1) else $error("ack lost"); // R10
   AST_RETI_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && hi_o && !set_i) |=> (!hi_o && lo_o == $past(lo_o))) else $error("reti order"); // R10
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
   parameter int NSRC       = 11,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8,
   localparam int IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_tick,
   input  logic [NSRC-1:0]   req_i,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [NSRC:0]     cfg_wdata,
   input  logic              last_cyc,
   input  logic              reg_wr,
   input  logic              reti_i,
   input  logic              ack_i,
   output logic              call_o,
   output logic [IDX_W-1:0]  call_idx,
   output logic [ADDR_W-1:0] call_vec,
   output logic [1:0]        svc_lvl
);
   import irq_nest_pkg::*;

   generate
      if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
         $error("NSRC must lie in 1..32");
      end
      if (ADDR_W != 16) begin : g_bad_addr
         $error("ADDR_W must be 16");
      end
      if (VEC_BASE + VEC_STRIDE * (NSRC - 1) >= (1 << ADDR_W)) begin : g_bad_vec
         $error("entry addresses overflow ADDR_W");
      end
   endgenerate

   logic [NSRC-1:0] en_q, pri_q, samp;
   logic            gie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pri_q <= '0;
         gie_q <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_sel) pri_q <= cfg_wdata[NSRC-1:0];
         else begin
            en_q  <= cfg_wdata[NSRC-1:0];
            gie_q <= cfg_wdata[NSRC];
         end
      end
   end

   irq_sampler #(.NSRC(NSRC)) u_samp (
      .clk(clk), .rst_n(rst_n), .tick(mc_tick), .req_i(req_i), .samp_o(samp));

   logic [NSRC-1:0]  cand, cand_hi, cand_lo, gnt_hi, gnt_lo;
   logic             vld_hi, vld_lo;
   logic [IDX_W-1:0] idx_hi, idx_lo;

   assign cand    = samp & en_q & {NSRC{gie_q}};
   assign cand_hi = cand & pri_q;
   assign cand_lo = cand & ~pri_q;

   irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick_hi (
      .cand_i(cand_hi), .vld_o(vld_hi), .idx_o(idx_hi), .grant_o(gnt_hi));
   irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick_lo (
      .cand_i(cand_lo), .vld_o(vld_lo), .idx_o(idx_lo), .grant_o(gnt_lo));

   logic svc_hi, svc_lo, pend_q;
   lvl_e pend_lvl_q;
   logic take_hi, take_lo, open_q, go;

   assign take_hi = vld_hi && !svc_hi;
   assign take_lo = !vld_hi && vld_lo && !svc_hi && !svc_lo;
   assign open_q  = last_cyc && !reg_wr && !reti_i && !pend_q;
   assign go      = mc_tick && open_q && (take_hi || take_lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         call_o     <= 1'b0;
         call_idx   <= '0;
         call_vec   <= '0;
         pend_q     <= 1'b0;
         pend_lvl_q <= LVL_LO;
      end else begin
         call_o <= go;
         if (go) begin
            call_idx   <= take_hi ? idx_hi : idx_lo;
            call_vec   <= entry_addr(VEC_BASE, VEC_STRIDE,
                                     int'(take_hi ? idx_hi : idx_lo));
            pend_q     <= 1'b1;
            pend_lvl_q <= take_hi ? LVL_HI : LVL_LO;
         end else if (ack_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   irq_nest_track u_nest (
      .clk(clk), .rst_n(rst_n), .set_i(ack_i && pend_q),
      .set_hi_i(pend_lvl_q == LVL_HI), .reti_i(reti_i),
      .hi_o(svc_hi), .lo_o(svc_lo));

   assign svc_lvl = {svc_hi, svc_lo};

   AST_CALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      call_o |=> !call_o) else $error("call held"); // R9
   AST_CALL_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      call_o |-> $past(mc_tick)) else $error("call without tick"); // R4
   AST_NO_CALL_IN_HI: assert property (@(posedge clk) disable iff (!rst_n)
      call_o |-> !$past(svc_hi)) else $error("call during high service"); // R6
   AST_GATED_BY_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      call_o |-> $past(last_cyc && !reg_wr && !reti_i)) else $error("blocked call"); // R7
endmodule

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mc_tick = 1'b0;
   logic [10:0] req_i = '0;
   logic        cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [11:0] cfg_wdata = '0;
   logic        last_cyc = 1'b0, reg_wr = 1'b0, reti_i = 1'b0, ack_i = 1'b0;
   logic        call_o;
   logic [3:0]  call_idx;
   logic [15:0] call_vec;
   logic [1:0]  svc_lvl;

   always #2 clk = ~clk;

   irq_nest_ctrl u_irq_nest_ctrl (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .req_i(req_i),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .last_cyc(last_cyc), .reg_wr(reg_wr), .reti_i(reti_i), .ack_i(ack_i),
      .call_o(call_o), .call_idx(call_idx), .call_vec(call_vec), .svc_lvl(svc_lvl));

   int total = 0, fails = 0, strays = 0;
   bit done = 1'b0;
   logic [3:0] expq[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && call_o) begin
         if (expq.size() == 0) begin
            strays++;
            chk(1'b0, "R2/R3/R6/R7/R8 stray call", call_idx, 0);
         end else begin
            logic [3:0] e;
            e = expq.pop_front();
            chk(call_idx == e, "R5 index", call_idx, e);
            chk(call_vec == 16'(3 + 8 * e), "R9 vector", call_vec, 3 + 8 * e);
         end
      end
   end

   task automatic cfg(input bit sel, input logic [11:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic tick(input bit lc, input bit rw, input bit rt);
      @(negedge clk); mc_tick = 1'b1; last_cyc = lc; reg_wr = rw; reti_i = rt;
      @(negedge clk); mc_tick = 1'b0; last_cyc = 1'b0; reg_wr = 1'b0; reti_i = 1'b0;
   endtask

   task automatic run(input logic [10:0] r, input bit lc, input bit rw, input bit rt,
                      input bit exp, input logic [3:0] idx, input string tag);
      int s0;
      s0 = strays;
      req_i = r;
      tick(1'b0, 1'b0, 1'b0);
      if (exp) expq.push_back(idx);
      tick(lc, rw, rt);
      chk(call_o == exp, {tag, " R4 timing"}, call_o, exp);
      @(negedge clk);
      chk(call_o == 1'b0, "R9 strobe width", call_o, 0);
      chk(expq.size() == 0 && strays == s0, tag, expq.size(), 0);
      expq.delete();
      req_i = '0;
   endtask

   task automatic ack();
      @(negedge clk); ack_i = 1'b1;
      @(negedge clk); ack_i = 1'b0;
   endtask

   task automatic ret();
      @(negedge clk); reti_i = 1'b1;
      @(negedge clk); reti_i = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(call_o == 1'b0 && svc_lvl == 2'b00, "R1 reset outputs", {call_o, svc_lvl}, 0);
      run(11'h7FF, 1, 0, 0, 0, 0, "R1 cleared config");

      cfg(1'b0, 12'hFFF);
      run(11'h020, 1, 0, 0, 1, 5, "R9 single low call");
      ack();
      chk(svc_lvl == 2'b01, "R10 low in service", svc_lvl, 1);
      run(11'h008, 1, 0, 0, 0, 0, "R6 low blocked by low");
      cfg(1'b1, 12'h080);
      run(11'h080, 1, 0, 0, 1, 7, "R6 high preempts low");
      ack();
      chk(svc_lvl == 2'b11, "R10 both in service", svc_lvl, 3);
      run(11'h080, 1, 0, 0, 0, 0, "R6 high blocked by high");
      ret();
      chk(svc_lvl == 2'b01, "R10 reti clears high first", svc_lvl, 1);
      ret();
      chk(svc_lvl == 2'b00, "R10 reti clears low", svc_lvl, 0);

      run(11'h044, 1, 0, 0, 1, 2, "R5 lowest index wins");
      ack(); ret();
      run(11'h082, 1, 0, 0, 1, 7, "R5 high beats low");
      ack(); ret();
      run(11'h400, 1, 0, 0, 1, 10, "R9 top vector");
      ack(); ret();

      cfg(1'b0, 12'h7FF);
      run(11'h020, 1, 0, 0, 0, 0, "R3 master off");
      cfg(1'b0, 12'hFDF);
      run(11'h020, 1, 0, 0, 0, 0, "R2 source disabled");
      cfg(1'b0, 12'hFFF);

      run(11'h010, 0, 0, 0, 0, 0, "R7 not last cycle");
      run(11'h010, 1, 1, 0, 0, 0, "R7 register write");
      run(11'h010, 1, 0, 1, 0, 0, "R7 return instruction");

      req_i = 11'h010;
      tick(1'b0, 1'b0, 1'b0);
      req_i = '0;
      tick(1'b0, 1'b0, 1'b0);
      tick(1'b1, 1'b0, 1'b0);
      @(negedge clk);
      chk(strays == 0, "R8 denied request dropped", strays, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule